// File: doc/BRIEF.md
# Script Instruction Fetch Sequencer

This block is a small command processor that walks a list of two-word instructions in memory without help from the host. The host writes a start address into the script pointer. The sequencer then reads two consecutive 32-bit words through a simple read port and decodes the top byte of the first word. A data-move instruction is passed to a separate DMA engine as a byte count and a memory address over a start/done handshake. When the engine reports completion, the sequencer fetches the next instruction.

The sequence stops on a halt instruction, on an unknown opcode, or on a misaligned start address. Each of these causes sets its own status bit. A host interrupt stays raised while any status bit is set, and the host clears the bits by writing ones to them. A fresh pointer write starts the sequencer again at any time it is idle.

Top module: `script_fetch_seq`

## Requirements
- R1: After synchronous reset, busy, irq, status, ptr_out, mem_req, dma_start, dma_count and dma_addr are all zero.
- R2: A pointer write while idle whose low three bits are zero loads the pointer, and in the next cycle mem_req is high with mem_addr equal to the written value.
- R3: An instruction fetch reads the word at the pointer and then the word at pointer+4. Each read holds mem_req and mem_addr steady until the cycle in which mem_rvalid is sampled high.
- R4: The opcode is bits 31:24 of the first word. Opcode 0x10 is a data move: dma_count takes bits 23:0 of the first word and dma_addr takes the second word. dma_start is a one-cycle pulse, and both command outputs hold their value until the next move is decoded.
- R5: The pointer advances by 8 when the second word is accepted. After dma_done the next fetch starts at the advanced pointer, and a move with a byte count of zero chains in the same way.
- R6: Opcode 0x98 stops the sequence (busy low) and sets status bit 0, which raises irq.
- R7: Any opcode other than 0x10 and 0x98 stops the sequence and sets status bit 1 (illegal instruction), which raises irq.
- R8: A pointer write while idle whose low three bits are not all zero leaves the pointer unchanged, issues no fetch, and sets status bit 2 (misaligned).
- R9: A status write clears each status bit written as 1 and leaves the bits written as 0. A bit set in the same cycle as its clear stays set. irq is high exactly while any status bit is set.
- R10: A pointer write while busy has no effect on the pointer or on the running sequence.
- R11: A pointer write while idle restarts execution even if status bits are still set, and those bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ptr_wr | input | 1 | Host write strobe for the script pointer |
| host_ptr_data | input | 32 | Start address written by the host |
| host_stat_wr | input | 1 | Host write strobe for the status register (write 1 to clear) |
| host_stat_data | input | 3 | Bits to clear: bit0 halt, bit1 illegal, bit2 misaligned |
| ptr_out | output | 32 | Current script pointer |
| busy | output | 1 | Sequence running |
| irq | output | 1 | Host interrupt, OR of the status bits |
| status | output | 3 | Sticky stop causes |
| mem_req | output | 1 | Instruction word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Read data |
| dma_start | output | 1 | One-cycle launch of a data move |
| dma_count | output | 24 | Byte count of the move |
| dma_addr | output | 32 | Memory address of the move |
| dma_done | input | 1 | Move completion from the DMA engine |

## Verification
The hardest case to produce is a host pointer write that lands while the sequencer is busy, in the middle of a fetch or a DMA wait. That write has to leave the pointer and the chained flow untouched. The bench slows the memory and the DMA responders so that the run lasts many cycles, and it issues the write during that window. A second hard case is a misaligned write arriving in the same cycle as a status clear of the same bit. The bench drives both strobes on one edge and checks that the set takes priority. A cycle-level model compares every output on every clock through multi-instruction chains, zero-length moves and restarts made without clearing status.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int OPC_W  = 8;
    localparam int CNT_W  = WORD_W - OPC_W;
    localparam int ST_W   = 3;

    // status bit positions
    localparam int ST_HALT    = 0;
    localparam int ST_ILLEGAL = 1;
    localparam int ST_ALIGN   = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_LO,
        S_FETCH_HI,
        S_DECODE,
        S_ISSUE,
        S_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        K_MOVE,
        K_HALT,
        K_ILLEGAL
    } op_kind_e;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] addr;
    } move_cmd_t;

    function automatic op_kind_e classify(input logic [OPC_W-1:0] op,
                                          input logic [OPC_W-1:0] mv_code,
                                          input logic [OPC_W-1:0] halt_code);
        if (op == mv_code)
            return K_MOVE;
        else if (op == halt_code)
            return K_HALT;
        else
            return K_ILLEGAL;
    endfunction
endpackage

// File: rtl/sfs_ptr_reg.sv
module sfs_ptr_reg
    import sfs_pkg::*;
#(
    parameter int ALIGN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv_en,
    output logic              load_aligned,
    output logic [ADDR_W-1:0] ptr_q
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_BITS;

    assign load_aligned = (load_val[ALIGN_BITS-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load_en)
            ptr_q <= load_val;
        else if (adv_en)
            ptr_q <= ptr_q + STEP;
    end
endmodule

// File: rtl/sfs_decode.sv
module sfs_decode
    import sfs_pkg::*;
#(
    parameter logic [OPC_W-1:0] OP_MOVE = 8'h10,
    parameter logic [OPC_W-1:0] OP_HALT = 8'h98
) (
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    output op_kind_e          kind,
    output move_cmd_t         cmd
);
    always_comb begin
        kind      = classify(word0[WORD_W-1 -: OPC_W], OP_MOVE, OP_HALT);
        cmd.count = word0[CNT_W-1:0];
        cmd.addr  = word1[ADDR_W-1:0];
    end
endmodule

// File: rtl/sfs_fetch_fsm.sv
module sfs_fetch_fsm
    import sfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              adv,
    output logic [WORD_W-1:0] w0_q,
    output logic [WORD_W-1:0] w1_q,
    input  op_kind_e          kind,
    input  move_cmd_t         cmd,
    output logic              dma_start,
    output logic [CNT_W-1:0]  dma_count,
    output logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_done,
    output logic              ev_halt,
    output logic              ev_illegal,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

    seq_state_e state_q, state_d;
    move_cmd_t  cmd_q;

    always_comb begin
        state_d    = state_q;
        mem_req    = 1'b0;
        mem_addr   = ptr;
        adv        = 1'b0;
        dma_start  = 1'b0;
        ev_halt    = 1'b0;
        ev_illegal = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start)
                    state_d = S_FETCH_LO;
            end
            S_FETCH_LO: begin
                mem_req = 1'b1;
                if (mem_rvalid)
                    state_d = S_FETCH_HI;
            end
            S_FETCH_HI: begin
                mem_req  = 1'b1;
                mem_addr = ptr + WORD_BYTES;
                if (mem_rvalid) begin
                    adv     = 1'b1;
                    state_d = S_DECODE;
                end
            end
            S_DECODE: begin
                unique case (kind)
                    K_MOVE:    state_d = S_ISSUE;
                    K_HALT: begin
                        ev_halt = 1'b1;
                        state_d = S_IDLE;
                    end
                    default: begin
                        ev_illegal = 1'b1;
                        state_d    = S_IDLE;
                    end
                endcase
            end
            S_ISSUE: begin
                dma_start = 1'b1;
                state_d   = S_WAIT;
            end
            S_WAIT: begin
                if (dma_done)
                    state_d = S_FETCH_LO;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            w0_q    <= '0;
            w1_q    <= '0;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_FETCH_LO && mem_rvalid)
                w0_q <= mem_rdata;
            if (state_q == S_FETCH_HI && mem_rvalid)
                w1_q <= mem_rdata;
            if (state_q == S_DECODE && kind == K_MOVE)
                cmd_q <= cmd;
        end
    end

    assign busy      = (state_q != S_IDLE);
    assign dma_count = cmd_q.count;
    assign dma_addr  = cmd_q.addr;

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R4
    dma_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dma_start |=> !dma_start);

    // R4
    dma_cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !dma_done && !dma_start) |=> ($stable(dma_count) || $past(state_q) == S_DECODE));
endmodule

// File: rtl/sfs_status.sv
module sfs_status
    import sfs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_vec,
    input  logic            clr_wr,
    input  logic [ST_W-1:0] clr_data,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status[i] <= 1'b0;
            else if (set_vec[i])
                status[i] <= 1'b1;
            else if (clr_wr && clr_data[i])
                status[i] <= 1'b0;
        end

        // R9
        sticky_bit_chk: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !(clr_wr && clr_data[i])) |=> status[i]);

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> status[i]);
    end

    assign irq = |status;
endmodule

// File: rtl/script_fetch_seq.sv
module script_fetch_seq
    import sfs_pkg::*;
#(
    parameter int                ALIGN_BITS = 3,
    parameter logic [OPC_W-1:0]  OP_MOVE    = 8'h10,
    parameter logic [OPC_W-1:0]  OP_HALT    = 8'h98
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_ptr_wr,
    input  logic [ADDR_W-1:0] host_ptr_data,
    input  logic              host_stat_wr,
    input  logic [ST_W-1:0]   host_stat_data,
    output logic [ADDR_W-1:0] ptr_out,
    output logic              busy,
    output logic              irq,
    output logic [ST_W-1:0]   status,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              dma_start,
    output logic [CNT_W-1:0]  dma_count,
    output logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_done
);
    logic              accept, aligned, start, adv;
    logic              ev_halt, ev_illegal;
    logic [WORD_W-1:0] w0, w1;
    logic [ST_W-1:0]   set_vec;
    op_kind_e          kind;
    move_cmd_t         cmd;

    assign accept = host_ptr_wr && !busy;
    assign start  = accept && aligned;

    sfs_ptr_reg #(.ALIGN_BITS(ALIGN_BITS)) u_ptr (
        .clk          (clk),
        .rst          (rst),
        .load_en      (start),
        .load_val     (host_ptr_data),
        .adv_en       (adv),
        .load_aligned (aligned),
        .ptr_q        (ptr_out)
    );

    sfs_decode #(.OP_MOVE(OP_MOVE), .OP_HALT(OP_HALT)) u_dec (
        .word0 (w0),
        .word1 (w1),
        .kind  (kind),
        .cmd   (cmd)
    );

    sfs_fetch_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ptr        (ptr_out),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .adv        (adv),
        .w0_q       (w0),
        .w1_q       (w1),
        .kind       (kind),
        .cmd        (cmd),
        .dma_start  (dma_start),
        .dma_count  (dma_count),
        .dma_addr   (dma_addr),
        .dma_done   (dma_done),
        .ev_halt    (ev_halt),
        .ev_illegal (ev_illegal),
        .busy       (busy)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[ST_HALT]    = ev_halt;
        set_vec[ST_ILLEGAL] = ev_illegal;
        set_vec[ST_ALIGN]   = accept && !aligned;
    end

    sfs_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_wr   (host_stat_wr),
        .clr_data (host_stat_data),
        .status   (status),
        .irq      (irq)
    );

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ptr_wr && !busy && host_ptr_data[ALIGN_BITS-1:0] == '0)
        |=> (mem_req && mem_addr == $past(host_ptr_data)));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (ptr_out == $past(ptr_out) + (ADDR_W'(1) << ALIGN_BITS)));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ptr_wr && busy && !adv) |=> $stable(ptr_out));

    // R8
    misalign_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ptr_wr && !busy && host_ptr_data[ALIGN_BITS-1:0] != '0)
        |=> (!busy && status[ST_ALIGN] && $stable(ptr_out)));
endmodule

// File: tb/sim_script_fetch_seq.sv
module sim_script_fetch_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_ptr_wr = 1'b0;
    logic [31:0] host_ptr_data = '0;
    logic        host_stat_wr = 1'b0;
    logic [2:0]  host_stat_data = '0;
    logic [31:0] ptr_out;
    logic        busy, irq;
    logic [2:0]  status;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        dma_start;
    logic [23:0] dma_count;
    logic [31:0] dma_addr;
    logic        dma_done = 1'b0;

    always #4 clk = ~clk;

    script_fetch_seq u0 (
        .clk(clk), .rst(rst),
        .host_ptr_wr(host_ptr_wr), .host_ptr_data(host_ptr_data),
        .host_stat_wr(host_stat_wr), .host_stat_data(host_stat_data),
        .ptr_out(ptr_out), .busy(busy), .irq(irq), .status(status),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .dma_start(dma_start), .dma_count(dma_count), .dma_addr(dma_addr),
        .dma_done(dma_done)
    );

    int vectors = 0;
    int errors  = 0;
    bit done_flag = 0;

    logic [31:0] mem [logic [31:0]];
    int mem_lat = 0;
    int dma_lat = 1;
    int mcnt = 0;
    int dcnt = 0;
    bit dactive = 0;

    // reference model state
    int          m_state = 0;   // 0 idle,1 lo,2 hi,3 dec,4 issue,5 wait
    logic [31:0] m_ptr = '0, m_w0 = '0, m_w1 = '0, m_daddr = '0;
    logic [23:0] m_cnt = '0;
    logic [2:0]  m_stat = '0;

    task automatic vec(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // reference model, advanced on each clock edge
    always @(posedge clk) begin
        logic [2:0] setv;
        logic [2:0] clrv;
        setv = '0;
        clrv = host_stat_wr ? host_stat_data : 3'b000;
        if (rst) begin
            m_state = 0; m_ptr = 0; m_w0 = 0; m_w1 = 0; m_cnt = 0; m_daddr = 0; m_stat = 0;
        end else begin
            case (m_state)
                0: if (host_ptr_wr) begin
                       if (host_ptr_data[2:0] == 3'b000) begin
                           m_ptr = host_ptr_data; m_state = 1;
                       end else setv[2] = 1'b1;
                   end
                1: if (mem_rvalid) begin m_w0 = mem_rdata; m_state = 2; end
                2: if (mem_rvalid) begin m_w1 = mem_rdata; m_ptr = m_ptr + 8; m_state = 3; end
                3: begin
                       if (m_w0[31:24] == 8'h10) begin
                           m_cnt = m_w0[23:0]; m_daddr = m_w1; m_state = 4;
                       end else if (m_w0[31:24] == 8'h98) begin
                           setv[0] = 1'b1; m_state = 0;
                       end else begin
                           setv[1] = 1'b1; m_state = 0;
                       end
                   end
                4: m_state = 5;
                5: if (dma_done) m_state = 1;
                default: m_state = 0;
            endcase
            m_stat = (m_stat & ~clrv) | setv;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            vec("R2", {31'b0, busy}, {31'b0, m_state != 0}, "busy");
            vec("R3", {31'b0, mem_req}, {31'b0, m_state == 1 || m_state == 2}, "mem_req");
            if (mem_req)
                vec("R3", mem_addr, (m_state == 2) ? m_ptr + 4 : m_ptr, "mem_addr");
            vec("R4", {31'b0, dma_start}, {31'b0, m_state == 4}, "dma_start");
            vec("R4", {8'b0, dma_count}, {8'b0, m_cnt}, "dma_count");
            vec("R4", dma_addr, m_daddr, "dma_addr");
            vec("R5", ptr_out, m_ptr, "ptr_out");
            vec("R9", {29'b0, status}, {29'b0, m_stat}, "status");
            vec("R9", {31'b0, irq}, {31'b0, m_stat != 0}, "irq");
        end
    end

    // memory responder
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mcnt = 0;
        end else if (mem_req) begin
            if (mcnt >= mem_lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rd(mem_addr);
            end else mcnt++;
        end
    end

    // DMA engine responder
    always @(negedge clk) begin
        dma_done = 1'b0;
        if (dactive) begin
            if (dcnt == 0) begin dma_done = 1'b1; dactive = 0; end
            else dcnt--;
        end
        if (dma_start) begin
            dactive = 1;
            dcnt = dma_lat - 1;
        end
    end

    task automatic put_move(input logic [31:0] a, input logic [23:0] c, input logic [31:0] d);
        mem[a]     = {8'h10, c};
        mem[a + 4] = d;
    endtask

    task automatic put_op(input logic [31:0] a, input logic [7:0] op);
        mem[a]     = {op, 24'h0};
        mem[a + 4] = 32'h0;
    endtask

    task automatic ptr_write(input logic [31:0] v);
        @(negedge clk);
        host_ptr_wr = 1'b1; host_ptr_data = v;
        @(negedge clk);
        host_ptr_wr = 1'b0;
    endtask

    task automatic stat_write(input logic [2:0] v);
        @(negedge clk);
        host_stat_wr = 1'b1; host_stat_data = v;
        @(negedge clk);
        host_stat_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // program A: two moves then halt
        put_move(32'h100, 24'h000040, 32'h0000_8000);
        put_move(32'h108, 24'h123456, 32'hDEAD_0000);
        put_op  (32'h110, 8'h98);
        // program B: move then unknown opcode
        put_move(32'h200, 24'h000100, 32'h0001_0000);
        put_op  (32'h208, 8'h55);
        // program C: halt only
        put_op  (32'h400, 8'h98);
        // program D: zero-length move then halt
        put_move(32'h500, 24'h000000, 32'h0002_0000);
        put_op  (32'h508, 8'h98);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        vec("R1", {29'b0, status}, 32'h0, "status after reset");
        vec("R1", ptr_out, 32'h0, "ptr after reset");
        vec("R1", {30'b0, busy, irq}, 32'h0, "busy/irq after reset");
        vec("R1", {30'b0, mem_req, dma_start}, 32'h0, "req/start after reset");

        // R2 R4 R5 R6: chained moves ending in halt
        mem_lat = 0; dma_lat = 2;
        ptr_write(32'h100);
        vec("R2", {31'b0, mem_req}, 32'h1, "fetch begins after write");
        vec("R2", mem_addr, 32'h100, "first fetch address");
        wait_idle();
        vec("R6", {29'b0, status}, 32'h1, "halt status");
        vec("R6", {31'b0, irq}, 32'h1, "halt irq");
        vec("R5", ptr_out, 32'h118, "pointer after three instructions");
        vec("R4", {8'b0, dma_count}, 32'h0012_3456, "last move count");
        vec("R4", dma_addr, 32'hDEAD_0000, "last move address");

        // R9 write-1-to-clear
        stat_write(3'b010);
        vec("R9", {29'b0, status}, 32'h1, "zero bit leaves status");
        stat_write(3'b001);
        vec("R9", {30'b0, irq, status[0]}, 32'h0, "cleared status and irq");

        // R7 R10: slow handshakes, pointer write while busy
        mem_lat = 3; dma_lat = 6;
        ptr_write(32'h200);
        repeat (6) @(negedge clk);
        ptr_write(32'h600);
        repeat (8) @(negedge clk);
        ptr_write(32'h608);
        wait_idle();
        vec("R7", {29'b0, status}, 32'h2, "illegal opcode status");
        vec("R10", ptr_out, 32'h210, "busy writes ignored");
        stat_write(3'b111);

        // R8 R9: misaligned write with a same-cycle clear of that bit
        @(negedge clk);
        host_ptr_wr = 1'b1; host_ptr_data = 32'h304;
        host_stat_wr = 1'b1; host_stat_data = 3'b100;
        @(negedge clk);
        host_ptr_wr = 1'b0; host_stat_wr = 1'b0;
        vec("R8", {31'b0, busy}, 32'h0, "no fetch on misaligned");
        vec("R8", ptr_out, 32'h210, "pointer kept on misaligned");
        vec("R9", {29'b0, status}, 32'h4, "set wins over clear");

        // R11 restart without clearing status
        mem_lat = 1;
        ptr_write(32'h400);
        wait_idle();
        vec("R11", {29'b0, status}, 32'h5, "status kept across restart");
        vec("R11", ptr_out, 32'h408, "restart pointer");
        stat_write(3'b101);

        // R5 zero-length move chains on
        dma_lat = 1; mem_lat = 0;
        ptr_write(32'h500);
        wait_idle();
        vec("R5", ptr_out, 32'h510, "zero count move chained");
        vec("R5", {8'b0, dma_count}, 32'h0, "zero count presented");
        vec("R6", {29'b0, status}, 32'h1, "halt after zero move");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule